// File: doc/BRIEF.md
# Barrel Context Rotator

This block lets ten virtual processors share one physical execution stage. It keeps ten register contexts, each holding a program counter, an accumulator, a small flag field and a halt bit. On every clock it presents one context to the shared stage and takes the updated context back. It then steps to the next context. Each virtual processor is served once per round of ten clocks, so it advances one step per round.

The shared stage computes a new context from the one presented. It returns that context on the write-back inputs in the same cycle, and the rotator stores it into the presented entry at the clock edge. A halted context keeps its slot, but its write-backs are dropped. A load port can set the program counter of any context that is not currently presented, and doing so also clears that context's halt bit.

Top module: `barrel_ctx_rotator`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the slot index is 0. Every context presents a program counter, accumulator, flags and halt bit of 0.
- R2: The slot index increases by one on each clock and returns from NUM_CTX-1 to 0.
- R3: The outputs always show the context of the current slot. With wb_valid high and the context not halted, the write-back values are stored into that context at the clock edge. They are presented when the slot comes round again NUM_CTX clocks later.
- R4: With wb_valid low, the presented context is unchanged when its slot next comes round.
- R5: Once a stored context has halt set to 1, every write-back to it is ignored: its program counter, accumulator, flags and halt bit stay as they were.
- R6: With ld_en high and ld_idx naming a context other than the current slot, that context's program counter takes ld_pc and its halt bit clears. Its accumulator and flags are unchanged.
- R7: A load whose ld_idx equals the current slot index is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Minor-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_valid | input | 1 | Write-back from the shared stage is valid |
| wb_pc | input | PC_W | Updated program counter |
| wb_acc | input | ACC_W | Updated accumulator |
| wb_flags | input | FLAG_W | Updated flags |
| wb_halt | input | 1 | Updated halt bit |
| ld_en | input | 1 | Program counter load request |
| ld_idx | input | IDX_W | Context targeted by the load |
| ld_pc | input | PC_W | Value loaded into the program counter |
| slot_idx | output | IDX_W | Context currently in the slot |
| cur_pc | output | PC_W | Presented program counter |
| cur_acc | output | ACC_W | Presented accumulator |
| cur_flags | output | FLAG_W | Presented flags |
| cur_halt | output | 1 | Presented halt bit |

## Verification
The bench builds the block with its defaults: ten contexts, 16-bit program counter and accumulator, and 4-bit flags. Ten contexts make the wrap from 9 to 0 a non-power-of-two boundary. The bench gives each context its own accumulator increment, so a write into the wrong entry, or a context served twice in one round, shows up as a wrong accumulator. Over eight rounds it covers a halt set in one round, a write-back that is then dropped, a load aimed at the active slot, a load aimed at a halted idle slot, and a round with no write-back.

// File: rtl/barrel_ctx_rotator.sv
module barrel_ctx_rotator #(
  parameter int NUM_CTX = 10,
  parameter int PC_W    = 16,
  parameter int ACC_W   = 16,
  parameter int FLAG_W  = 4,
  localparam int IDX_W  = $clog2(NUM_CTX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_valid,
  input  logic [PC_W-1:0]   wb_pc,
  input  logic [ACC_W-1:0]  wb_acc,
  input  logic [FLAG_W-1:0] wb_flags,
  input  logic              wb_halt,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [PC_W-1:0]   ld_pc,
  output logic [IDX_W-1:0]  slot_idx,
  output logic [PC_W-1:0]   cur_pc,
  output logic [ACC_W-1:0]  cur_acc,
  output logic [FLAG_W-1:0] cur_flags,
  output logic              cur_halt
);
  logic [IDX_W-1:0] slot_q;
  logic [NUM_CTX-1:0][PC_W-1:0]   pc_q;
  logic [NUM_CTX-1:0][ACC_W-1:0]  acc_q;
  logic [NUM_CTX-1:0][FLAG_W-1:0] flag_q;
  logic [NUM_CTX-1:0]             halt_q;

  wire last_slot = (slot_q == IDX_W'(NUM_CTX - 1));
  wire wb_take   = wb_valid && !halt_q[slot_q];
  wire ld_take   = ld_en && (ld_idx != slot_q) &&
                   ({1'b0, ld_idx} < (IDX_W + 1)'(NUM_CTX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
      pc_q   <= '0;
      acc_q  <= '0;
      flag_q <= '0;
      halt_q <= '0;
    end else begin
      slot_q <= last_slot ? '0 : slot_q + 1'b1;
      if (wb_take) begin
        pc_q[slot_q]   <= wb_pc;
        acc_q[slot_q]  <= wb_acc;
        flag_q[slot_q] <= wb_flags;
        halt_q[slot_q] <= wb_halt;
      end
      if (ld_take) begin
        pc_q[ld_idx]   <= ld_pc;
        halt_q[ld_idx] <= 1'b0;
      end
    end
  end

  assign slot_idx  = slot_q;
  assign cur_pc    = pc_q[slot_q];
  assign cur_acc   = acc_q[slot_q];
  assign cur_flags = flag_q[slot_q];
  assign cur_halt  = halt_q[slot_q];
endmodule

module barrel_ctx_chk #(
  parameter int NUM_CTX = 10,
  parameter int PC_W    = 16,
  parameter int IDX_W   = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [IDX_W-1:0]             slot_idx,
  input logic [PC_W-1:0]              cur_pc,
  input logic                         cur_halt,
  input logic                         ld_en,
  input logic [IDX_W-1:0]             ld_idx,
  input logic [PC_W-1:0]              ld_pc,
  input logic [NUM_CTX-1:0][PC_W-1:0] pc_q
);
  // R1
  reset_slot_chk: assert property (@(posedge clk) !rst_n |=> slot_idx == '0);
  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_idx != IDX_W'(NUM_CTX - 1)) |=> slot_idx == $past(slot_idx) + 1'b1);
  // R2
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_idx == IDX_W'(NUM_CTX - 1)) |=> slot_idx == '0);
  // R5
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_halt && !(ld_en && ld_idx == slot_idx)) |=> pc_q[$past(slot_idx)] == $past(cur_pc));
  // R6
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_idx != slot_idx && {1'b0, ld_idx} < (IDX_W + 1)'(NUM_CTX))
    |=> pc_q[$past(ld_idx)] == $past(ld_pc));
endmodule

bind barrel_ctx_rotator barrel_ctx_chk #(
  .NUM_CTX(NUM_CTX), .PC_W(PC_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_idx(slot_idx), .cur_pc(cur_pc),
  .cur_halt(cur_halt), .ld_en(ld_en), .ld_idx(ld_idx), .ld_pc(ld_pc),
  .pc_q(pc_q)
);

// File: tb/test_barrel_ctx_rotator.sv
module test_barrel_ctx_rotator;
  localparam int CLK_PERIOD = 10;
  localparam int N = 10;
  localparam int NONE = 15;
  // per round: [12] wb_valid, [11:8] slot that writes halt, [7:4] load target, [3:0] slot at which load is issued
  localparam logic [12:0] PLAN [8] = '{
    13'h1_F_FF, 13'h1_3_FF, 13'h1_F_FF, 13'h1_F_33,
    13'h1_F_35, 13'h0_F_FF, 13'h1_F_FF, 13'h1_F_FF };
  localparam string LBL [8] = '{"R1", "R3", "R5", "R5", "R7", "R6", "R4", "R3"};

  logic clk = 0, rst_n = 0;
  logic wb_valid = 0, wb_halt = 0, ld_en = 0;
  logic [15:0] wb_pc = 0, wb_acc = 0, ld_pc = 0;
  logic [3:0] wb_flags = 0, ld_idx = 0;
  logic [3:0] slot_idx, cur_flags;
  logic [15:0] cur_pc, cur_acc;
  logic cur_halt;
  int n_chk = 0, n_fail = 0;
  logic [15:0] m_pc [N], m_acc [N];
  logic [3:0] m_fl [N];
  logic m_ht [N];

  always #(CLK_PERIOD / 2) clk = ~clk;

  barrel_ctx_rotator i_barrel_ctx_rotator (
    .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_pc(wb_pc), .wb_acc(wb_acc),
    .wb_flags(wb_flags), .wb_halt(wb_halt), .ld_en(ld_en), .ld_idx(ld_idx), .ld_pc(ld_pc),
    .slot_idx(slot_idx), .cur_pc(cur_pc), .cur_acc(cur_acc), .cur_flags(cur_flags),
    .cur_halt(cur_halt));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_pc[i] = 0; m_acc[i] = 0; m_fl[i] = 0; m_ht[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R1", slot_idx, 0);
    chk("R1", {cur_pc, cur_acc}, 0);
    chk("R1", {cur_flags, cur_halt}, 0);
    rst_n = 1;
    for (int r = 0; r < 8; r++) begin
      for (int s = 0; s < N; s++) begin
        chk("R2", slot_idx, s);
        chk(LBL[r], cur_pc, m_pc[s]);
        chk(LBL[r], cur_acc, m_acc[s]);
        chk(LBL[r], {cur_flags, cur_halt}, {m_fl[s], m_ht[s]});
        wb_valid = PLAN[r][12];
        wb_pc    = cur_pc + 16'd1;
        wb_acc   = cur_acc + 16'(s * 3 + 1);
        wb_flags = cur_flags + 4'd1;
        wb_halt  = (PLAN[r][11:8] == 4'(s));
        ld_en    = (PLAN[r][3:0] == 4'(s)) && (PLAN[r][7:4] != 4'(NONE));
        ld_idx   = PLAN[r][7:4];
        ld_pc    = 16'h1230 + 16'(r);
        if (wb_valid && !m_ht[s]) begin
          m_pc[s] = wb_pc; m_acc[s] = wb_acc; m_fl[s] = wb_flags; m_ht[s] = wb_halt;
        end
        if (ld_en && int'(ld_idx) != s && int'(ld_idx) < N) begin
          m_pc[ld_idx] = ld_pc; m_ht[ld_idx] = 1'b0;
        end
        @(negedge clk);
      end
    end
    wb_valid = 0; ld_en = 0;
    // R1: reset taken mid-run returns slot and contexts to zero
    repeat (4) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk("R1", slot_idx, 0);
    chk("R1", {cur_pc, cur_acc}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R2", slot_idx, 1);
    chk("R1", {cur_pc, cur_acc, cur_flags, 3'b0, cur_halt}, 0);
    finish_run();
  end
endmodule